// File: doc/BRIEF.md
# Masked Status Interrupt Vector Unit

This block keeps the sticky event flags of a byte-oriented serial bus controller. It also holds a five-bit interrupt enable mask and a two-bit DMA configuration. From these it drives one level interrupt line and two DMA request lines, one for each data direction.

The data path sets flags with one-cycle set pulses and clears them with one-cycle clear pulses. Software uses a small register port with a single address, a read strobe, a write strobe and write data. Reads return data combinationally in the cycle the strobe is high. Any read side effect takes place at the clock edge that ends that cycle.

The vector register lets an interrupt handler find the most urgent enabled event and acknowledge it with one access. Reading the vector returns the index of the lowest set enabled flag, plus one, and clears that flag.

Top module: `evt_status_vec`

## Requirements
- R1: After reset, the status, enable and DMA registers read zero, and `irq_o`, `rx_dma_req` and `tx_dma_req` are low.
- R2: A set pulse makes a status flag sticky-high, but only at bit positions 1, 2, 3, 4, 9, 10, 11 and 15. Set pulses at every other position leave those status bits at zero.
- R3: A clear pulse drops the flag at that position. When a set pulse and a clear pulse hit the same bit in the same cycle, the bit ends up set.
- R4: Reading the status register (address 1) returns the stored flags, with bit 12 replaced by the live `bus_busy` input. Bit 12 is never stored.
- R5: A write to the enable register (address 0) keeps only `wdata[4:0]`. `irq_o` is the registered OR of (status AND enable). It changes one clock after the status or enable bits change.
- R6: Reading the vector register (address 2) returns 1 plus the position of the lowest set bit of (status AND enable), or 0 when none is set. The read clears that single status bit and no other.
- R7: When a vector read clears a bit and a set pulse targets the same bit in the same cycle, the bit stays set.
- R8: A write to the DMA register (address 3) keeps only bits 15 (receive DMA enable) and 7 (transmit DMA enable). Writing bit 15 as 1 clears enable bit 3. Writing bit 7 as 1 clears enable bit 4.
- R9: `rx_dma_req` is the registered value of (status bit 3 AND receive DMA enable). `tx_dma_req` is the registered value of (status bit 4 AND transmit DMA enable).
- R10: Writes to the status and vector addresses change no register.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| set_evt | input | 16 | One-cycle set pulses, one per status bit |
| clr_evt | input | 16 | One-cycle clear pulses, one per status bit |
| bus_busy | input | 1 | Live bus-busy indication shown in status bit 12 |
| addr | input | 2 | Register select: 0 enable, 1 status, 2 vector, 3 DMA |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| wdata | input | 16 | Write data |
| rdata | output | 16 | Read data, valid while `rd_en` is high |
| irq_o | output | 1 | Registered interrupt request |
| rx_dma_req | output | 1 | Registered receive DMA request |
| tx_dma_req | output | 1 | Registered transmit DMA request |

## Verification
The bench runs successive vector reads over several pending flags. If the priority were reversed, the first read would return the highest index. If the clear were applied to the wrong bit, a later read would return that same index again. The bench also lands a set pulse on the very bit that a vector read is clearing, and a set pulse on a bit that a clear pulse is dropping. A design that let the clear win would lose the new event. Further tests write all ones to the DMA register, which catches a design that fails to mask enable bits 3 and 4 or that stores unused bits. Writes to the status and vector addresses catch decoders that let those writes reach the flags.

// File: rtl/evt_status_vec.sv
module evt_status_vec (
  input  logic        clk,
  input  logic        rst_n,
  input  logic [15:0] set_evt,
  input  logic [15:0] clr_evt,
  input  logic        bus_busy,
  input  logic [1:0]  addr,
  input  logic        rd_en,
  input  logic        wr_en,
  input  logic [15:0] wdata,
  output logic [15:0] rdata,
  output logic        irq_o,
  output logic        rx_dma_req,
  output logic        tx_dma_req
);
  localparam logic [15:0] FLAG_MAP = 16'h8E1E;
  localparam logic [1:0]  A_EN = 2'd0, A_ST = 2'd1, A_VEC = 2'd2, A_DMA = 2'd3;
  localparam int RX_EN_BIT = 15, TX_EN_BIT = 7;

  logic [15:0] stat_q;
  logic [4:0]  en_q;
  logic        rx_en_q, tx_en_q;
  logic [15:0] pend;
  logic [2:0]  vec_idx;
  logic [15:0] vec_clr;

  assign pend = stat_q & {11'd0, en_q};

  always_comb begin
    vec_idx = 3'd0;
    for (int i = 4; i >= 0; i--)
      if (pend[i]) vec_idx = 3'(i + 1);
  end

  always_comb begin
    vec_clr = '0;
    if (rd_en && addr == A_VEC && vec_idx != 3'd0)
      vec_clr[vec_idx - 3'd1] = 1'b1;
  end

  always_comb begin
    case (addr)
      A_EN:    rdata = {11'd0, en_q};
      A_ST:    rdata = {stat_q[15:13], bus_busy, stat_q[11:0]};
      A_VEC:   rdata = {13'd0, vec_idx};
      default: rdata = {rx_en_q, 7'd0, tx_en_q, 7'd0};
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      stat_q  <= '0;
      en_q    <= '0;
      rx_en_q <= 1'b0;
      tx_en_q <= 1'b0;
    end else begin
      stat_q <= ((stat_q & ~clr_evt & ~vec_clr) | set_evt) & FLAG_MAP;
      if (wr_en && addr == A_EN) en_q <= wdata[4:0];
      if (wr_en && addr == A_DMA) begin
        rx_en_q <= wdata[RX_EN_BIT];
        tx_en_q <= wdata[TX_EN_BIT];
        if (wdata[RX_EN_BIT]) en_q[3] <= 1'b0;
        if (wdata[TX_EN_BIT]) en_q[4] <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      irq_o      <= 1'b0;
      rx_dma_req <= 1'b0;
      tx_dma_req <= 1'b0;
    end else begin
      irq_o      <= |pend;
      rx_dma_req <= rx_en_q & stat_q[3];
      tx_dma_req <= tx_en_q & stat_q[4];
    end
  end
endmodule

module evt_status_vec_chk (
  input logic        clk,
  input logic        rst_n,
  input logic [15:0] set_evt,
  input logic [15:0] clr_evt,
  input logic        bus_busy,
  input logic [1:0]  addr,
  input logic        rd_en,
  input logic        wr_en,
  input logic [15:0] wdata,
  input logic [15:0] rdata,
  input logic        irq_o,
  input logic        rx_dma_req,
  input logic        tx_dma_req,
  input logic [15:0] stat_q,
  input logic [4:0]  en_q,
  input logic        rx_en_q
);
  // R5
  irq_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> irq_o == $past(|(stat_q & {11'd0, en_q})));
  // R3
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((set_evt & 16'h8E1E) != 16'd0) |=> ((stat_q & $past(set_evt & 16'h8E1E)) == $past(set_evt & 16'h8E1E)));
  // R10
  illegal_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !rd_en && (addr == 2'd1 || addr == 2'd2) && set_evt == 16'd0 && clr_evt == 16'd0)
    |=> ($stable(stat_q) && $stable(en_q)));
  // R8
  dma_mask_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && addr == 2'd3 && wdata[15]) |=> !en_q[3]);
  // R9
  rx_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> rx_dma_req == $past(rx_en_q & stat_q[3]));
  // R4
  busy_view_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd1) |-> rdata[12] == bus_busy);
  // R6
  vec_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_en && addr == 2'd2 && rdata != 16'd0 && set_evt == 16'd0)
    |=> !stat_q[$past(rdata[2:0]) - 3'd1]);
endmodule

bind evt_status_vec evt_status_vec_chk u_chk (
  .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt),
  .bus_busy(bus_busy), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
  .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .rx_dma_req(rx_dma_req),
  .tx_dma_req(tx_dma_req), .stat_q(stat_q), .en_q(en_q), .rx_en_q(rx_en_q)
);

// File: tb/evt_status_vec_test.sv
module evt_status_vec_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [15:0] set_evt = '0, clr_evt = '0, wdata = '0;
  logic        bus_busy = 1'b0, rd_en = 1'b0, wr_en = 1'b0;
  logic [1:0]  addr = '0;
  logic [15:0] rdata;
  logic        irq_o, rx_dma_req, tx_dma_req;
  int checks = 0, fails = 0;

  always #2.5 clk = ~clk;

  evt_status_vec uut (
    .clk(clk), .rst_n(rst_n), .set_evt(set_evt), .clr_evt(clr_evt),
    .bus_busy(bus_busy), .addr(addr), .rd_en(rd_en), .wr_en(wr_en),
    .wdata(wdata), .rdata(rdata), .irq_o(irq_o), .rx_dma_req(rx_dma_req),
    .tx_dma_req(tx_dma_req)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic [1:0] a, output logic [15:0] v);
    @(negedge clk); addr = a; rd_en = 1'b1; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic pulse(input logic [15:0] s, input logic [15:0] c);
    @(negedge clk); set_evt = s; clr_evt = c;
    @(negedge clk); set_evt = '0; clr_evt = '0;
  endtask

  task automatic t_reset;
    logic [15:0] v;
    chk("R1 irq", {15'd0, irq_o}, 16'd0);
    chk("R1 dma reqs", {14'd0, rx_dma_req, tx_dma_req}, 16'd0);
    rd(2'd0, v); chk("R1 enable", v, 16'd0);
    rd(2'd1, v); chk("R1 status", v, 16'd0);
    rd(2'd3, v); chk("R1 dma", v, 16'd0);
  endtask

  task automatic t_set_clear;
    logic [15:0] v;
    pulse(16'hFFFF, 16'h0);
    rd(2'd1, v); chk("R2 only mapped bits", v, 16'h8E1E);
    pulse(16'h0, 16'h0E00);
    rd(2'd1, v); chk("R3 clear pulse", v, 16'h801E);
    pulse(16'h0002, 16'h8002);
    rd(2'd1, v); chk("R3 set beats clear", v, 16'h001E);
    pulse(16'h0, 16'hFFFF);
    rd(2'd1, v); chk("R3 clear all", v, 16'h0);
  endtask

  task automatic t_busy;
    logic [15:0] v;
    bus_busy = 1'b1;
    rd(2'd1, v); chk("R4 busy shown", v, 16'h1000);
    bus_busy = 1'b0;
    rd(2'd1, v); chk("R4 busy not stored", v, 16'h0);
  endtask

  task automatic t_irq;
    logic [15:0] v;
    wr(2'd0, 16'hFFFF);
    rd(2'd0, v); chk("R5 enable width", v, 16'h001F);
    pulse(16'h0200, 16'h0);
    @(negedge clk); chk("R5 disabled flag no irq", {15'd0, irq_o}, 16'd0);
    @(negedge clk); set_evt = 16'h0004;
    @(negedge clk); set_evt = 16'h0;
    chk("R5 irq not yet", {15'd0, irq_o}, 16'd0);
    @(negedge clk); chk("R5 irq one clock later", {15'd0, irq_o}, 16'd1);
    wr(2'd0, 16'h0);
    @(negedge clk); chk("R5 irq drops with enable", {15'd0, irq_o}, 16'd0);
    pulse(16'h0, 16'hFFFF);
  endtask

  task automatic t_vector;
    logic [15:0] v;
    wr(2'd0, 16'h001F);
    pulse(16'h0214, 16'h0);
    rd(2'd2, v); chk("R6 lowest first", v, 16'd3);
    rd(2'd1, v); chk("R6 only that bit cleared", v, 16'h0210);
    rd(2'd2, v); chk("R6 next index", v, 16'd5);
    rd(2'd2, v); chk("R6 none enabled", v, 16'd0);
    rd(2'd1, v); chk("R6 disabled flag kept", v, 16'h0200);
    pulse(16'h0, 16'hFFFF);
  endtask

  task automatic t_vec_race;
    logic [15:0] v;
    pulse(16'h0002, 16'h0);
    @(negedge clk); addr = 2'd2; rd_en = 1'b1; set_evt = 16'h0002; #1 v = rdata;
    @(negedge clk); rd_en = 1'b0; set_evt = 16'h0;
    chk("R7 vector value", v, 16'd2);
    rd(2'd1, v); chk("R7 set beats read clear", v, 16'h0002);
    pulse(16'h0, 16'hFFFF);
  endtask

  task automatic t_dma;
    logic [15:0] v;
    wr(2'd0, 16'h001F);
    wr(2'd3, 16'hFFFF);
    rd(2'd3, v); chk("R8 dma width", v, 16'h8080);
    rd(2'd0, v); chk("R8 enables 3,4 cleared", v, 16'h0007);
    pulse(16'h0008, 16'h0);
    @(negedge clk);
    chk("R9 rx req", {14'd0, rx_dma_req, tx_dma_req}, 16'h2);
    pulse(16'h0010, 16'h0);
    @(negedge clk);
    chk("R9 both reqs", {14'd0, rx_dma_req, tx_dma_req}, 16'h3);
    wr(2'd3, 16'h0);
    @(negedge clk);
    chk("R9 reqs gated off", {14'd0, rx_dma_req, tx_dma_req}, 16'h0);
    wr(2'd0, 16'h001F);
    wr(2'd3, 16'h0080);
    rd(2'd0, v); chk("R8 tx enable clears bit 4", v, 16'h000F);
    wr(2'd3, 16'h0);
    pulse(16'h0, 16'hFFFF);
  endtask

  task automatic t_illegal;
    logic [15:0] v;
    wr(2'd0, 16'h0005);
    pulse(16'h0400, 16'h0);
    wr(2'd1, 16'hFFFF);
    wr(2'd2, 16'hFFFF);
    rd(2'd1, v); chk("R10 status unchanged", v, 16'h0400);
    rd(2'd0, v); chk("R10 enable unchanged", v, 16'h0005);
    rd(2'd3, v); chk("R10 dma unchanged", v, 16'h0000);
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_set_clear();
        t_busy();
        t_irq();
        t_vector();
        t_vec_race();
        t_dma();
        t_illegal();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule